// File: doc/BRIEF.md
# Eight-Channel Serial Switch-Control Front End

This block is the serial slave that sits between a host's SPI master and eight low-side switch drivers. The host lowers chip select, clocks a frame of control bits into an eight-bit shift register, and raises chip select again. If the number of serial clocks in the frame was a non-zero multiple of eight, the last eight bits received move into an output latch that drives eight enable lines. A control bit of 1 means the channel is off. When chip select falls, eight per-channel status bits are loaded into the same shift register, and they leave on the serial output while the new control bits come in.

All serial pins are oversampled by the system clock through a synchronizer, so the serial clock must be several times slower than the system clock. Because the shift register passes bits through with a delay of eight serial clocks, several of these blocks can be chained output-to-input, and one frame then carries eight bits per block. A functional clear forces every channel off and empties the shift register. This clear is the OR of an active-low clear pin and an undervoltage flag.

Top module: `spi_oc_top`

## Requirements
- R1: The block samples `sdi` on a falling edge of `sclk`. `sdo` changes only after a rising edge of `sclk` or a falling edge of `cs_n`, and it holds its value across a falling edge of `sclk`.
- R2: Data moves MSB first. In an eight-clock frame, the first bit shifted in controls channel 7 (`drive_en[7]`) and the last bit controls channel 0.
- R3: A latched control bit of 1 turns its channel off (`drive_en[i]=0`), and a control bit of 0 turns it on (`drive_en[i]=1`).
- R4: When `cs_n` rises, the shift register moves into the latch only if the number of `sclk` cycles since `cs_n` fell is 8, 16, 24 or any other non-zero multiple of 8. For 0, 7 or 9 clocks, `drive_en` keeps its previous value.
- R5: When `cs_n` falls, `chan_stat` is loaded into the shift register with `chan_stat[7]` in the MSB. `sdo` then presents `chan_stat[7]`, and the next seven rising edges of `sclk` present `chan_stat[6]` down to `chan_stat[0]`.
- R6: While `cs_n` is high, `sclk` and `sdi` have no effect and `sdo_oe` is 0. `sdo_oe` is 1 while `cs_n` is low.
- R7: While `clr_n` is 0 or `uv_flag` is 1, the shift register is cleared to zero and all `drive_en` bits are 0. The `sdo` value and the frame clock count are not disturbed.
- R8: Cascade: a bit shifted in appears on `sdo` eight `sclk` cycles later, in the order it entered. A sixteen-clock frame latches the last eight bits.
- R9: `drive_en` shows a committed frame no more than 4 `clk` cycles after `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset of all state |
| clr_n | input | 1 | Active-low functional clear |
| uv_flag | input | 1 | Undervoltage indication, active high, ORed into the clear |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| chan_stat | input | 8 | Per-channel status bits, captured when a frame starts |
| sdo | output | 1 | Serial data out, meaningful while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output-enable for the `sdo` pad (0 means high impedance) |
| drive_en | output | 8 | Channel enables, 1 = switch on |

## Verification
The bench sends frames of 0, 7, 8, 9 and 16 clocks. A frame filter that counted bits modulo eight without a "full byte seen" flag would accept the empty frame, and one that compared for exactly eight would reject the sixteen-clock frame. The bench also reads status back and checks that `sdo` holds steady across every falling `sclk` edge. A design that shifted on the wrong edge, or loaded status late, would skip or repeat `chan_stat[7]`. A clear is pulsed in the middle of a frame: a design that also reset `sdo` or the clock count would fail either the hold check or the commit that follows. The bench then toggles `sclk` and `sdi` with chip select high, to confirm that nothing changes on `drive_en`, `sdo_oe` or the next frame's data.

// File: rtl/spi_oc_pkg.sv
package spi_oc_pkg;

    // Index of each serial pin inside the synchronizer vector
    localparam int unsigned PIN_SDI  = 0;
    localparam int unsigned PIN_SCLK = 1;
    localparam int unsigned PIN_CSN  = 2;
    localparam int unsigned PIN_CNT  = 3;

    // Idle level of each synchronized pin {cs_n, sclk, sdi}
    localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b100;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_OPEN = 1'b1
    } frame_st_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

    // Control bit polarity: 1 programs off
    function automatic logic ctl_to_enable(input logic ctl_bit);
        return ~ctl_bit;
    endfunction

endpackage

// File: rtl/spi_oc_sync.sv
module spi_oc_sync
    import spi_oc_pkg::*;
#(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output pin_ev_t          ev_o [WIDTH]
);
    localparam int unsigned DEPTH = STAGES + 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        logic [DEPTH-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {DEPTH{IDLE[b]}};
            end else begin
                chain <= {chain[DEPTH-2:0], pin_i[b]};
            end
        end

        assign ev_o[b].level = chain[STAGES-1];
        assign ev_o[b].rise  = chain[STAGES-1] & ~chain[STAGES];
        assign ev_o[b].fall  = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/spi_oc_shifter.sv
module spi_oc_shifter
    import spi_oc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         sdi,
    input  logic [W-1:0] stat,
    output logic [W-1:0] sr_o,
    output logic         sdo_o,
    output logic         frame_ok_o,
    output frame_st_e    state_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

    logic [W-1:0]  sr;
    logic [CW-1:0] cnt;
    logic          full_seen;
    logic          sdo_q;
    frame_st_e     state;

    logic shift_en;
    logic out_en;

    assign shift_en = (state == FR_OPEN) && sclk_fall && !cs_fall;
    assign out_en   = (state == FR_OPEN) && sclk_rise && !cs_fall;

    // Frame state follows the synchronized chip select
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FR_IDLE;
        end else if (cs_fall) begin
            state <= FR_OPEN;
        end else if (cs_rise) begin
            state <= FR_IDLE;
        end
    end

    // Shift register: clear wins, then frame-start load, then shift
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr <= '0;
        end else if (cs_fall) begin
            sr <= stat;
        end else if (shift_en) begin
            sr <= {sr[W-2:0], sdi};
        end
    end

    // Clock counter modulo W with a sticky full-word flag
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            full_seen <= 1'b0;
        end else if (cs_fall) begin
            cnt       <= '0;
            full_seen <= 1'b0;
        end else if (shift_en) begin
            if (cnt == CNT_LAST) begin
                cnt       <= '0;
                full_seen <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Serial output register, unaffected by the functional clear
    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
        end else if (cs_fall) begin
            sdo_q <= stat[W-1];
        end else if (out_en) begin
            sdo_q <= sr[W-1];
        end
    end

    assign sr_o       = sr;
    assign sdo_o      = sdo_q;
    assign frame_ok_o = full_seen && (cnt == '0);
    assign state_o    = state;

endmodule

// File: rtl/spi_oc_latch.sv
module spi_oc_latch
    import spi_oc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         commit,
    input  logic [W-1:0] ctl_i,
    output logic [W-1:0] ctl_o,
    output logic [W-1:0] enable_o
);
    logic [W-1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctl_q <= '1;
        end else if (commit) begin
            ctl_q <= ctl_i;
        end
    end

    for (genvar c = 0; c < W; c++) begin : g_ch
        assign enable_o[c] = ctl_to_enable(ctl_q[c]);
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/spi_oc_top.sv
module spi_oc_top
    import spi_oc_pkg::*;
#(
    parameter int unsigned CHANNELS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_n,
    input  logic                uv_flag,
    input  logic                sclk,
    input  logic                sdi,
    input  logic                cs_n,
    input  logic [CHANNELS-1:0] chan_stat,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [CHANNELS-1:0] drive_en
);
    pin_ev_t ev [PIN_CNT];

    logic                clr;
    logic                cs_act;
    logic                cs_fall;
    logic                cs_rise;
    logic                commit;
    logic                frame_ok;
    logic                sdo_d;
    logic [CHANNELS-1:0] sr;
    logic [CHANNELS-1:0] ctl;
    frame_st_e           state;

    spi_oc_sync #(
        .WIDTH  (PIN_CNT),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i ({cs_n, sclk, sdi}),
        .ev_o  (ev)
    );

    assign clr     = ~clr_n | uv_flag;
    assign cs_act  = ~ev[PIN_CSN].level;
    assign cs_fall = ev[PIN_CSN].fall;
    assign cs_rise = ev[PIN_CSN].rise;

    spi_oc_shifter #(
        .W (CHANNELS)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sclk_rise  (ev[PIN_SCLK].rise),
        .sclk_fall  (ev[PIN_SCLK].fall),
        .sdi        (ev[PIN_SDI].level),
        .stat       (chan_stat),
        .sr_o       (sr),
        .sdo_o      (sdo_d),
        .frame_ok_o (frame_ok),
        .state_o    (state)
    );

    assign commit = cs_rise && frame_ok && (state == FR_OPEN);

    spi_oc_latch #(
        .W (CHANNELS)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .commit   (commit),
        .ctl_i    (sr),
        .ctl_o    (ctl),
        .enable_o (drive_en)
    );

    assign sdo    = sdo_d;
    assign sdo_oe = cs_act;

endmodule

// File: rtl/spi_oc_checker.sv
module spi_oc_checker #(
    parameter int unsigned CHANNELS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                clr,
    input logic                cs_act,
    input logic                cs_fall,
    input logic                cs_rise,
    input logic                sclk_rise,
    input logic                frame_ok,
    input logic                sdo_d,
    input logic [CHANNELS-1:0] sr,
    input logic [CHANNELS-1:0] ctl,
    input logic [CHANNELS-1:0] drive_en
);

    AST_SDO_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (!$past(sclk_rise) && !$past(cs_fall)) |-> $stable(sdo_d)); // R1

    AST_LATCH_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        (ctl != $past(ctl)) |-> (($past(cs_rise) && $past(frame_ok)) || $past(clr))); // R4

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        $past(cs_fall) |-> !frame_ok); // R4

    AST_CLEAR_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (drive_en == '0 && sr == '0)); // R7

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!$past(cs_act) && !$past(clr) && !$past(cs_fall)) |-> $stable(sr)); // R6

endmodule

bind spi_oc_top spi_oc_checker #(
    .CHANNELS (CHANNELS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .cs_act    (cs_act),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_rise (ev[PIN_SCLK].rise),
    .frame_ok  (frame_ok),
    .sdo_d     (sdo_d),
    .sr        (sr),
    .ctl       (ctl),
    .drive_en  (drive_en)
);

// File: tb/tb_spi_oc_top.sv
`timescale 1ns/1ps
module tb_spi_oc_top;

    localparam int HP = 8;  // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_n = 1'b1;
    logic       uv_flag = 1'b0;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] chan_stat = 8'h00;
    logic       sdo;
    logic       sdo_oe;
    logic [7:0] drive_en;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_en = 8'h00;

    always #2 clk = ~clk;

    spi_oc_top dut (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .uv_flag   (uv_flag),
        .sclk      (sclk),
        .sdi       (sdi),
        .cs_n      (cs_n),
        .chan_stat (chan_stat),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .drive_en  (drive_en)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits taken MSB-first from bits; returns sdo seen after each rise
    task automatic xfer(input int nbits, input logic [31:0] bits,
                        output logic [31:0] so_cap, output int r1_bad);
        so_cap = '0;
        r1_bad = 0;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int k = 0; k < nbits; k++) begin
            logic hi;
            sdi = bits[nbits-1-k];
            wait_clk(HP);
            sclk = 1'b1;
            wait_clk(HP);
            hi = sdo;
            so_cap = {so_cap[30:0], hi};
            sclk = 1'b0;
            wait_clk(HP);
            if (sdo !== hi) r1_bad++;
        end
        cs_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic t_reset;
        check(drive_en == 8'h00, "R7 reset all off", drive_en, 8'h00);
        check(sdo_oe == 1'b0, "R6 sdo hi-z at idle", sdo_oe, 0);
    endtask

    task automatic t_byte;
        logic [31:0] so; int r1b;
        chan_stat = 8'hA5;
        cs_n = 1'b0;
        wait_clk(4);
        check(sdo_oe == 1'b1, "R6 sdo enabled on select", sdo_oe, 1);
        check(sdo == 1'b1, "R5 first status bit is ch7", sdo, 1);
        cs_n = 1'b1;
        wait_clk(HP);
        // 0 clocks: rejected, still all off
        check(drive_en == exp_en, "R4 zero-clock frame ignored", drive_en, exp_en);
        xfer(8, 32'h53, so, r1b);
        exp_en = 8'hAC;  // ~0x53
        check(drive_en == exp_en, "R2 R3 R9 eight-clock commit", drive_en, exp_en);
        check(so[7:0] == 8'hA5, "R5 status readback", so[7:0], 8'hA5);
        check(r1b == 0, "R1 sdo steady across falling sclk", r1b, 0);
        check(sdo_oe == 1'b0, "R6 sdo released after frame", sdo_oe, 0);
    endtask

    task automatic t_first_bit_ch7;
        logic [31:0] so; int r1b;
        wait_clk(HP);
        xfer(8, 32'h7F, so, r1b);  // only first bit 0 -> only channel 7 on
        exp_en = 8'h80;
        check(drive_en == exp_en, "R2 first bit drives channel 7", drive_en, exp_en);
    endtask

    task automatic t_bad_lengths;
        logic [31:0] so; int r1b;
        wait_clk(HP);
        xfer(7, 32'h00, so, r1b);
        check(drive_en == exp_en, "R4 seven-clock frame ignored", drive_en, exp_en);
        wait_clk(HP);
        xfer(9, 32'h000, so, r1b);
        check(drive_en == exp_en, "R4 nine-clock frame ignored", drive_en, exp_en);
        wait_clk(HP);
        cs_n = 1'b0; wait_clk(3 * HP); cs_n = 1'b1; wait_clk(4);
        check(drive_en == exp_en, "R4 empty frame ignored", drive_en, exp_en);
    endtask

    task automatic t_cascade;
        logic [31:0] so; int r1b;
        chan_stat = 8'h3C;
        wait_clk(HP);
        xfer(16, 32'h0FF0, so, r1b);
        exp_en = 8'h0F;  // ~0xF0, last byte
        check(drive_en == exp_en, "R8 R4 sixteen-clock frame keeps last byte", drive_en, exp_en);
        check(so[15:8] == 8'h3C, "R5 status in cascade frame", so[15:8], 8'h3C);
        check(so[7:0] == 8'h0F, "R8 first byte forwarded on sdo", so[7:0], 8'h0F);
        check(r1b == 0, "R1 sdo steady in long frame", r1b, 0);
    endtask

    task automatic t_idle_ignored;
        logic [31:0] so; int r1b;
        for (int k = 0; k < 6; k++) begin
            sdi = k[0];
            sclk = 1'b1; wait_clk(HP);
            sclk = 1'b0; wait_clk(HP);
            check(sdo_oe == 1'b0, "R6 sdo hi-z while deselected", sdo_oe, 0);
        end
        check(drive_en == exp_en, "R6 idle clocks leave outputs", drive_en, exp_en);
        chan_stat = 8'h96;
        xfer(8, 32'hFF, so, r1b);
        check(so[7:0] == 8'h96, "R6 idle clocks left no trace in next frame", so[7:0], 8'h96);
        exp_en = 8'h00;
        check(drive_en == exp_en, "R3 all-ones frame turns all off", drive_en, exp_en);
    endtask

    task automatic t_clear_mid_frame;
        logic held;
        chan_stat = 8'hFF;
        wait_clk(HP);
        cs_n = 1'b0; wait_clk(HP);
        sdi = 1'b1;
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1; wait_clk(HP);
            sclk = 1'b0; wait_clk(HP);
        end
        held = sdo;
        clr_n = 1'b0; wait_clk(3);
        check(drive_en == 8'h00, "R7 clear turns outputs off", drive_en, 8'h00);
        check(sdo == held, "R7 clear leaves sdo alone", sdo, held);
        clr_n = 1'b1; wait_clk(2);
        sclk = 1'b1; wait_clk(HP);
        check(sdo == 1'b0, "R7 clear emptied shift register", sdo, 0);
        sclk = 1'b0; wait_clk(HP);
        sdi = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b1; wait_clk(HP);
            sclk = 1'b0; wait_clk(HP);
        end
        cs_n = 1'b1; wait_clk(4);
        // eight clocks total; register after clear then shifted 1,0,0,0,0 -> 0x10
        exp_en = 8'hEF;
        check(drive_en == exp_en, "R7 clock count kept through clear", drive_en, exp_en);
    endtask

    task automatic t_undervolt;
        uv_flag = 1'b1; wait_clk(3);
        exp_en = 8'h00;
        check(drive_en == exp_en, "R7 undervoltage turns outputs off", drive_en, exp_en);
        uv_flag = 1'b0; wait_clk(3);
        check(drive_en == exp_en, "R7 outputs stay off after undervoltage", drive_en, exp_en);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_byte();
        t_first_bit_ch7();
        t_bad_lengths();
        t_cascade();
        t_idle_ignored();
        t_clear_mid_frame();
        t_undervolt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule